// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds return addresses for a small 4-bit controller core. It has eight entries, each as wide as the program counter, and a 3-bit pointer. Three sources can push onto it: a subroutine call, entry into an interrupt, and a table lookup instruction. Each push takes one entry. A return instruction pops the stack, and so does a return from interrupt. During the pop cycle the block shows the stored address so the core can reload its program counter. The stored value is the address of the call instruction itself. The core runs that instruction once more as a no-operation and then moves on.

The pointer rests at 7 after reset and after a wake-up from the low-power retention mode. A push advances the pointer first and then writes, so the first push lands in entry 0. The pointer wraps in both directions with no warning. When more than eight entries are pushed, the oldest one is lost.

A separate one-deep context register is also part of the block. On interrupt entry it captures the data pointer, carry, skip flag, A and B. A return from interrupt hands these values back, so a pending skip survives the interrupt. Calls and table lookups never touch this register. The pointer is always available, zero-extended to the accumulator width, so that the core can copy it into A.

Top module: `rstk_top`

## Requirements
- R1: After reset, accPtr reads 7 (binary 0111), and popValid and ctxRestore are low.
- R2: A wakeReq pulse sets the pointer to 7 on the next edge and leaves the stored entries unchanged. It overrides any push or pop requested in the same cycle.
- R3: A push first advances the pointer by one and then writes pcIn into the entry the pointer now selects. The first push after reset writes entry 0, and from the next cycle retAddr shows the pushed value.
- R4: callReq, intReq and tblReq each use exactly one entry.
- R5: During a cycle with retReq or retIntReq, popValid is high and retAddr equals the entry at the current pointer. The pointer is one lower in the next cycle.
- R6: A push with the pointer at 7 wraps it to 0 and overwrites entry 0. No flag is raised.
- R7: A pop with the pointer at 0 wraps it to 7. No flag is raised.
- R8: If a push and a pop are requested in the same cycle, only the push takes effect: popValid and ctxRestore stay low.
- R9: The context outputs (dpOut, carryOut, skipOut, aOut, bOut) change only on an accepted intReq, which captures dpIn, carryIn, skipIn, aIn and bIn. Calls and table lookups leave them as they were.
- R10: An accepted retIntReq raises ctxRestore for that cycle. The values saved at interrupt entry, including the skip flag, are on the context outputs.
- R11: accPtr always equals the 3-bit pointer with a 0 in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wakeReq | input | 1 | Leaving low-power retention mode; reloads the pointer to 7 |
| callReq | input | 1 | Subroutine call push |
| intReq | input | 1 | Interrupt entry push and context capture |
| tblReq | input | 1 | Table lookup push |
| retReq | input | 1 | Return pop |
| retIntReq | input | 1 | Return from interrupt: pop and context restore |
| pcIn | input | 14 | Program counter value to push |
| dpIn | input | 6 | Data pointer to capture |
| carryIn | input | 1 | Carry flag to capture |
| skipIn | input | 1 | Skip flag to capture |
| aIn | input | 4 | Register A to capture |
| bIn | input | 4 | Register B to capture |
| retAddr | output | 14 | Entry at the current pointer |
| popValid | output | 1 | A pop is accepted this cycle |
| accPtr | output | 4 | Pointer zero-extended for transfer to A |
| ctxRestore | output | 1 | The context outputs are to be restored this cycle |
| dpOut | output | 6 | Saved data pointer |
| carryOut | output | 1 | Saved carry flag |
| skipOut | output | 1 | Saved skip flag |
| aOut | output | 4 | Saved register A |
| bOut | output | 4 | Saved register B |

## Verification
The pointer is always visible on accPtr. A wrong advance, wrap or reload therefore shows up on the very next cycle after the operation. A write that goes to the wrong entry, or that gets lost, stays hidden until it is read. It appears on retAddr either in the cycle right after the push or in the pop that reaches that entry, possibly several operations later. The bench therefore unwinds every nested and wrapped sequence it builds. The context register holds its value between interrupts, so an unwanted capture is checked on its outputs after every operation.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef struct packed {
    logic ptrReload;
    logic push;
    logic pop;
    logic ctxSave;
    logic ctxRestore;
  } rstkStrobes_t;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wakeReq,
  input  logic             callReq,
  input  logic             intReq,
  input  logic             tblReq,
  input  logic             retReq,
  input  logic             retIntReq,
  output rstkStrobes_t     strb,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] wrIdx
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

  logic anyPush;
  logic anyPop;
  logic [PTR_W-1:0] ptrDec;

  assign anyPush = callReq | intReq | tblReq;
  assign anyPop  = retReq | retIntReq;

  always_comb begin
    strb.ptrReload  = wakeReq;
    strb.push       = anyPush & ~wakeReq;
    strb.pop        = anyPop & ~anyPush & ~wakeReq;
    strb.ctxSave    = intReq & ~wakeReq;
    strb.ctxRestore = retIntReq & ~anyPush & ~wakeReq;
  end

  assign wrIdx  = (ptr == TOP_IDX) ? '0 : ptr + 1'b1;
  assign ptrDec = (ptr == '0) ? TOP_IDX : ptr - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptr <= TOP_IDX;
    else if (strb.ptrReload) ptr <= TOP_IDX;
    else if (strb.push)      ptr <= wrIdx;
    else if (strb.pop)       ptr <= ptrDec;
  end
endmodule

// File: rtl/rstk_datapath.sv
module rstk_datapath
  import rstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 14,
  parameter int DP_W  = 6,
  parameter int REG_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rstkStrobes_t     strb,
  input  logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [DP_W-1:0]  dpIn,
  input  logic             carryIn,
  input  logic             skipIn,
  input  logic [REG_W-1:0] aIn,
  input  logic [REG_W-1:0] bIn,
  output logic [PC_W-1:0]  retAddr,
  output logic [DP_W-1:0]  dpOut,
  output logic             carryOut,
  output logic             skipOut,
  output logic [REG_W-1:0] aOut,
  output logic [REG_W-1:0] bOut
);
  logic [PC_W-1:0] entryQ [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entryQ[g] <= '0;
      else if (strb.push && (wrIdx == PTR_W'(g)))
        entryQ[g] <= pcIn;
    end
  end

  assign retAddr = entryQ[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpOut    <= '0;
      carryOut <= 1'b0;
      skipOut  <= 1'b0;
      aOut     <= '0;
      bOut     <= '0;
    end else if (strb.ctxSave) begin
      dpOut    <= dpIn;
      carryOut <= carryIn;
      skipOut  <= skipIn;
      aOut     <= aIn;
      bOut     <= bIn;
    end
  end
endmodule

// File: rtl/rstk_top.sv
module rstk_top
  import rstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 14,
  parameter int DP_W  = 6,
  parameter int REG_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wakeReq,
  input  logic             callReq,
  input  logic             intReq,
  input  logic             tblReq,
  input  logic             retReq,
  input  logic             retIntReq,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [DP_W-1:0]  dpIn,
  input  logic             carryIn,
  input  logic             skipIn,
  input  logic [REG_W-1:0] aIn,
  input  logic [REG_W-1:0] bIn,
  output logic [PC_W-1:0]  retAddr,
  output logic             popValid,
  output logic [REG_W-1:0] accPtr,
  output logic             ctxRestore,
  output logic [DP_W-1:0]  dpOut,
  output logic             carryOut,
  output logic             skipOut,
  output logic [REG_W-1:0] aOut,
  output logic [REG_W-1:0] bOut
);
  rstkStrobes_t     strb;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] wrIdx;

  rstk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .callReq(callReq),
    .intReq(intReq), .tblReq(tblReq), .retReq(retReq), .retIntReq(retIntReq),
    .strb(strb), .ptr(ptr), .wrIdx(wrIdx)
  );

  rstk_datapath #(.DEPTH(DEPTH), .PC_W(PC_W), .DP_W(DP_W), .REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ptr(ptr), .wrIdx(wrIdx),
    .pcIn(pcIn), .dpIn(dpIn), .carryIn(carryIn), .skipIn(skipIn),
    .aIn(aIn), .bIn(bIn), .retAddr(retAddr), .dpOut(dpOut),
    .carryOut(carryOut), .skipOut(skipOut), .aOut(aOut), .bOut(bOut)
  );

  assign popValid   = strb.pop;
  assign ctxRestore = strb.ctxRestore;
  assign accPtr     = {{(REG_W - PTR_W){1'b0}}, ptr};
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 14,
  parameter int DP_W  = 6,
  parameter int REG_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wakeReq,
  input logic             callReq,
  input logic             intReq,
  input logic             tblReq,
  input logic             retReq,
  input logic             retIntReq,
  input logic [PC_W-1:0]  pcIn,
  input logic [DP_W-1:0]  dpIn,
  input logic             carryIn,
  input logic             skipIn,
  input logic [REG_W-1:0] aIn,
  input logic [REG_W-1:0] bIn,
  input logic [PC_W-1:0]  retAddr,
  input logic             popValid,
  input logic [REG_W-1:0] accPtr,
  input logic             ctxRestore,
  input logic [DP_W-1:0]  dpOut,
  input logic             carryOut,
  input logic             skipOut,
  input logic [REG_W-1:0] aOut,
  input logic [REG_W-1:0] bOut
);
  logic anyPush;
  logic [PTR_W-1:0] p;
  logic [DP_W+2*REG_W+1:0] ctxBus;

  assign anyPush = callReq | intReq | tblReq;
  assign p       = accPtr[PTR_W-1:0];
  assign ctxBus  = {dpOut, carryOut, skipOut, aOut, bOut};

  a_r2_wake_reload: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> p == PTR_W'(DEPTH - 1));

  a_r3_push_advance: assert property (@(posedge clk) disable iff (!rstN)
    (anyPush && !wakeReq) |=> p == PTR_W'($past(p) + 1'b1));

  a_r3_push_data: assert property (@(posedge clk) disable iff (!rstN)
    (anyPush && !wakeReq) |=> retAddr == $past(pcIn));

  a_r5_pop_retreat: assert property (@(posedge clk) disable iff (!rstN)
    popValid |=> p == PTR_W'($past(p) - 1'b1));

  a_r8_push_wins: assert property (@(posedge clk) disable iff (!rstN)
    anyPush |-> (!popValid && !ctxRestore));

  a_r9_ctx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(intReq && !wakeReq) |=> $stable(ctxBus));

  a_r10_restore_pops: assert property (@(posedge clk) disable iff (!rstN)
    ctxRestore |-> (popValid && retIntReq));

  a_r11_acc_upper: assert property (@(posedge clk) disable iff (!rstN)
    accPtr[REG_W-1:PTR_W] == '0);
endmodule

bind rstk_top rstk_checker #(.DEPTH(DEPTH), .PC_W(PC_W), .DP_W(DP_W), .REG_W(REG_W)) chk_i (.*);

// File: tb/rstk_top_tb_top.sv
module rstk_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeReq = 0, callReq = 0, intReq = 0, tblReq = 0, retReq = 0, retIntReq = 0;
  logic [13:0] pcIn = '0;
  logic [5:0]  dpIn = '0;
  logic        carryIn = 0, skipIn = 0;
  logic [3:0]  aIn = '0, bIn = '0;
  logic [13:0] retAddr;
  logic        popValid, ctxRestore, carryOut, skipOut;
  logic [3:0]  accPtr, aOut, bOut;
  logic [5:0]  dpOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [13:0] mStack [8];
  int          mPtr = 7;
  logic [5:0]  sDp = '0;
  logic        sCarry = 0, sSkip = 0;
  logic [3:0]  sA = '0, sB = '0;

  always #5 clk = ~clk;

  rstk_top dut_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .callReq(callReq), .intReq(intReq),
    .tblReq(tblReq), .retReq(retReq), .retIntReq(retIntReq), .pcIn(pcIn),
    .dpIn(dpIn), .carryIn(carryIn), .skipIn(skipIn), .aIn(aIn), .bIn(bIn),
    .retAddr(retAddr), .popValid(popValid), .accPtr(accPtr), .ctxRestore(ctxRestore),
    .dpOut(dpOut), .carryOut(carryOut), .skipOut(skipOut), .aOut(aOut), .bOut(bOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkCtx(input string req);
    check(dpOut == sDp && carryOut == sCarry && skipOut == sSkip && aOut == sA && bOut == sB,
          req, {dpOut, carryOut, skipOut, aOut, bOut}, {sDp, sCarry, sSkip, sA, sB});
  endtask

  // One cycle of stimulus; we enter and leave at a falling edge.
  task automatic doOp(input bit c, input bit i, input bit t, input bit r, input bit ri,
                      input bit w, input logic [13:0] pc, input logic [5:0] dp,
                      input bit cy, input bit sk, input logic [3:0] a, input logic [3:0] b);
    bit push, pop, rest;
    callReq = c; intReq = i; tblReq = t; retReq = r; retIntReq = ri; wakeReq = w;
    pcIn = pc; dpIn = dp; carryIn = cy; skipIn = sk; aIn = a; bIn = b;
    push = (c | i | t) & ~w;
    pop  = (r | ri) & ~(c | i | t) & ~w;
    rest = ri & ~(c | i | t) & ~w;
    #1;
    check(popValid == pop, "R5/R8 popValid", popValid, pop);
    check(ctxRestore == rest, "R10/R8 ctxRestore", ctxRestore, rest);
    if (pop) check(retAddr == mStack[mPtr], "R5 retAddr on pop", retAddr, mStack[mPtr]);
    if (rest) checkCtx("R10 restored context");
    @(posedge clk);
    @(negedge clk);
    callReq = 0; intReq = 0; tblReq = 0; retReq = 0; retIntReq = 0; wakeReq = 0;
    if (w) mPtr = 7;
    else if (push) begin
      mPtr = (mPtr + 1) % 8;
      mStack[mPtr] = pc;
      if (i) begin sDp = dp; sCarry = cy; sSkip = sk; sA = a; sB = b; end
    end else if (pop) mPtr = (mPtr + 7) % 8;
    check(accPtr == 4'(mPtr), "R11 accPtr", accPtr, mPtr);
    if (push) check(retAddr == pc, "R3 retAddr after push", retAddr, pc);
    checkCtx("R9 context outputs");
  endtask

  task automatic callOp(input logic [13:0] pc);
    doOp(1, 0, 0, 0, 0, 0, pc, 6'h15, 1, 0, 4'h9, 4'h6);
  endtask
  task automatic retOp();
    doOp(0, 0, 0, 1, 0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic testReset();
    check(accPtr == 4'b0111, "R1 accPtr after reset", accPtr, 7);
    check(!popValid && !ctxRestore, "R1 strobes low", {popValid, ctxRestore}, 0);
  endtask

  task automatic testFirstCall();
    callOp(14'h0101);
    check(accPtr == 0, "R3 first push lands in entry 0", accPtr, 0);
    retOp();
    check(accPtr == 7, "R5 call then return restores pointer 7", accPtr, 7);
  endtask

  task automatic testSources();
    callOp(14'h0010);
    doOp(0, 0, 1, 0, 0, 0, 14'h0020, 6'h2A, 0, 0, 4'h1, 4'h2);
    check(accPtr == 1, "R4 table lookup uses one entry", accPtr, 1);
    checkCtx("R9 table lookup leaves context");
    doOp(0, 1, 0, 0, 0, 0, 14'h0030, 6'h3C, 1, 1, 4'hA, 4'h5);
    check(accPtr == 2, "R4 interrupt uses one entry", accPtr, 2);
    check(skipOut == 1 && dpOut == 6'h3C, "R9 interrupt captures context", {dpOut, skipOut}, {6'h3C, 1'b1});
    doOp(1, 0, 0, 0, 0, 0, 14'h0040, 6'h01, 0, 0, 4'h3, 4'h3);
    check(accPtr == 3, "R4 call uses one entry", accPtr, 3);
    retOp();
    doOp(0, 0, 0, 0, 1, 0, '0, '0, 0, 0, '0, '0);
    check(skipOut == 1, "R10 skip flag survives interrupt", skipOut, 1);
    retOp();
    retOp();
    check(accPtr == 7, "R4 stack unwound", accPtr, 7);
  endtask

  task automatic testWrap();
    callOp(14'h0222);
    doOp(0, 0, 0, 0, 0, 1, 14'h3FFF, '0, 0, 0, '0, '0);
    check(accPtr == 7, "R2 wake reloads pointer", accPtr, 7);
    check(retAddr == mStack[7], "R2 wake keeps entries", retAddr, mStack[7]);
    for (int k = 0; k < 8; k++) callOp(14'h0100 + 14'(k));
    check(accPtr == 7, "R6 eight pushes fill stack", accPtr, 7);
    callOp(14'h03AA);
    check(accPtr == 0 && retAddr == 14'h03AA, "R6 ninth push overwrites entry 0", {accPtr, retAddr}, {4'h0, 14'h03AA});
    retOp();
    check(accPtr == 7, "R7 pop at 0 wraps to 7", accPtr, 7);
    for (int k = 0; k < 7; k++) retOp();
    check(accPtr == 0, "R7 unwound to entry 0", accPtr, 0);
    retOp();
    check(accPtr == 7, "R7 second wrap", accPtr, 7);
  endtask

  task automatic testConflict();
    doOp(1, 0, 0, 1, 0, 0, 14'h0555, 6'h00, 0, 0, '0, '0);
    check(accPtr == 0, "R8 push wins over return", accPtr, 0);
    doOp(0, 1, 0, 0, 1, 0, 14'h0666, 6'h11, 0, 1, 4'h7, 4'h8);
    check(accPtr == 1 && ctxRestore == 0, "R8 interrupt wins over restore", {accPtr, ctxRestore}, {4'h1, 1'b0});
    doOp(1, 0, 0, 0, 0, 1, 14'h0777, '0, 0, 0, '0, '0);
    check(accPtr == 7, "R2 wake overrides push", accPtr, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstCall();
    testSources();
    testWrap();
    testConflict();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial for (int k = 0; k < 8; k++) mStack[k] = '0;
endmodule